// File: doc/BRIEF.md
# Byte-Bus Register Readout and Service-Request Controller

This block sits on the slave side of a byte-wide instrument bus. Each bus transaction carries a board address and a register sub-address. The block decides whether the transaction is meant for this board. A transaction matches when its board address equals the board's own address, or when it uses the fixed broadcast address. Writes to the broadcast address are taken by every board. Reads happen only on the board's own address.

Most register reads return one byte. The exception is the data-memory sub-address, which streams the acquisition memory one 16-bit word at a time. Each word takes two successive reads: the high byte first, then the low byte. Only after the low byte does the word pointer move on.

A single service-request flag is raised when the acquisition engine reports that the memory has been filled. Software can poll the flag through the interrupt register without servicing it. The flag is cleared by any write to the interrupt register, whatever the data, or by the start-acquisition command. The start command also rewinds the memory pointer.

Top module: `regbus_irq_readout`

## Requirements
- R1: A read at sub-address 0x0C returns the high byte of the word at `ram_addr` on the first read and the low byte on the next read of 0x0C.
- R2: `ram_addr` advances by one only after the low byte of a word has been returned. After word RAM_DEPTH-1 it wraps to word 0.
- R3: Sub-addresses 0x00 to NREG-1 are byte registers that can be written and read back. A read of an unmapped sub-address returns 0x00. Reads of non-data sub-addresses and writes to 0x0C leave the data pointer and its byte phase unchanged.
- R4: Read data appears on `rd_data` in the cycle after `rd_en`, with `rd_valid` high for exactly that one cycle.
- R5: A `ram_done` pulse raises `irq_req` in the following cycle, and the flag holds until it is cleared.
- R6: A read at sub-address 0x08 returns 0x01 while the flag is set and 0x00 otherwise. Reading it does not clear the flag.
- R7: Any write to sub-address 0x08 clears the flag, whatever the written data.
- R8: A write to sub-address 0x09 (start acquisition) clears the flag and rewinds the data pointer to word 0, high byte.
- R9: When `ram_done` and a clearing write fall in the same cycle, the flag ends up clear.
- R10: A write with `bus_addr` = 30 is accepted whatever `board_id` is. A write addressed to another board is ignored.
- R11: A read at bus address 30, or at another board's address, produces no `rd_valid` and does not move the data pointer.
- R12: After reset, `irq_req`, `rd_valid`, `rd_data`, `ram_addr` and all byte registers are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| board_id | input | 5 | This board's own bus address |
| bus_addr | input | 5 | Board address of the current transaction |
| sub_addr | input | 8 | Register sub-address |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data valid, one cycle |
| ram_done | input | 1 | Memory-filled pulse from the acquisition engine |
| ram_addr | output | AW | Word address presented to the data memory |
| ram_word | input | 16 | Word read from the data memory at `ram_addr` |
| irq_req | output | 1 | Service-request line |

## Verification
The most damaging internal fault is a byte-phase bit that is out of step with the pointer. It shows within two reads of 0x0C: the bytes come back swapped, a word repeats, or a word is skipped. Interleaving other register reads between the two halves of a word exposes a phase that is disturbed by foreign reads. A flag stuck high or stuck low shows at `irq_req` one cycle after the offending event, and the same value is visible through a read of 0x08. Pointer wrap errors stay hidden until a full pass over the memory, so the bench streams every word once and then checks that the next high byte belongs to word 0.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam logic [7:0] SUB_DATA  = 8'h0C;
  localparam logic [7:0] SUB_FLAG  = 8'h08;
  localparam logic [7:0] SUB_START = 8'h09;
  localparam logic [4:0] BCAST_ID  = 5'd30;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SCRATCH,
    TGT_DATA,
    TGT_FLAG,
    TGT_START
  } target_e;
endpackage

// File: rtl/regbus_decode.sv
module regbus_decode
  import regbus_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic [4:0] board_id,
  input  logic [4:0] bus_addr,
  input  logic [7:0] sub_addr,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic       wr_ok,
  output logic       rd_ok,
  output target_e    tgt
);
  logic own_hit;
  logic bc_hit;

  always_comb begin
    own_hit = (bus_addr == board_id) && (bus_addr != BCAST_ID);
    bc_hit  = (bus_addr == BCAST_ID);
    wr_ok   = wr_en && (own_hit || bc_hit);
    rd_ok   = rd_en && !wr_en && own_hit;
    if (sub_addr == SUB_DATA)        tgt = TGT_DATA;
    else if (sub_addr == SUB_FLAG)   tgt = TGT_FLAG;
    else if (sub_addr == SUB_START)  tgt = TGT_START;
    else if (32'(sub_addr) < NREG)   tgt = TGT_SCRATCH;
    else                             tgt = TGT_NONE;
  end

  always_comb begin
    if (rd_en && bus_addr == BCAST_ID)
      ast_no_bcast_rd: assert (!rd_ok); // R11
  end
endmodule

// File: rtl/regbus_irq_flag.sv
module regbus_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i)      flag_d = 1'b0;
    else if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_SET_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> flag_q); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag_q); // R9
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_q)); // R6
endmodule

// File: rtl/regbus_word_seq.sv
module regbus_word_seq #(
  parameter int RAM_DEPTH = 10252,
  localparam int AW = $clog2(RAM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          take_i,
  input  logic [15:0]   word_i,
  output logic [7:0]    byte_o,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(RAM_DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          lo_q, lo_d;

  always_comb begin
    ptr_d = ptr_q;
    lo_d  = lo_q;
    if (start_i) begin
      ptr_d = '0;
      lo_d  = 1'b0;
    end else if (take_i) begin
      lo_d = !lo_q;
      if (lo_q) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      lo_q  <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      lo_q  <= lo_d;
    end
  end

  assign byte_o = lo_q ? word_i[7:0] : word_i[15:8];
  assign ptr_o  = ptr_q;

  AST_HIGH_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !lo_q && !start_i) |=> $stable(ptr_q)); // R2
  AST_LOW_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && lo_q && !start_i && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1)); // R2
  AST_START_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ptr_q == '0 && !lo_q)); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !start_i) |=> ($stable(ptr_q) && $stable(lo_q))); // R3
endmodule

// File: rtl/regbus_irq_readout.sv
module regbus_irq_readout
  import regbus_pkg::*;
#(
  parameter int RAM_DEPTH = 10252,
  parameter int NREG      = 8,
  localparam int AW       = $clog2(RAM_DEPTH),
  localparam int SAW      = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    board_id,
  input  logic [4:0]    bus_addr,
  input  logic [7:0]    sub_addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  input  logic          ram_done,
  output logic [AW-1:0] ram_addr,
  input  logic [15:0]   ram_word,
  output logic          irq_req
);
  logic       rst_s1, rst_sn;
  logic       wr_ok, rd_ok;
  target_e    tgt;
  logic       start_cmd, flag_clr, take_word;
  logic [7:0] data_byte;
  logic [7:0] scr_q [NREG];
  logic [7:0] mux_byte;
  logic [7:0] rd_data_q, rd_data_d;
  logic       rd_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  regbus_decode #(.NREG(NREG)) u_dec (
    .board_id(board_id), .bus_addr(bus_addr), .sub_addr(sub_addr),
    .wr_en(wr_en), .rd_en(rd_en), .wr_ok(wr_ok), .rd_ok(rd_ok), .tgt(tgt)
  );

  assign start_cmd = wr_ok && (tgt == TGT_START);
  assign flag_clr  = start_cmd || (wr_ok && tgt == TGT_FLAG);
  assign take_word = rd_ok && (tgt == TGT_DATA);

  regbus_irq_flag u_flag (
    .clk(clk), .rst_n(rst_sn), .set_i(ram_done), .clr_i(flag_clr), .flag_o(irq_req)
  );

  regbus_word_seq #(.RAM_DEPTH(RAM_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_sn), .start_i(start_cmd), .take_i(take_word),
    .word_i(ram_word), .byte_o(data_byte), .ptr_o(ram_addr)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_scr
    logic scr_en;
    assign scr_en = wr_ok && (tgt == TGT_SCRATCH) && (sub_addr[SAW-1:0] == SAW'(g));
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)     scr_q[g] <= '0;
      else if (scr_en) scr_q[g] <= wr_data;
    end
  end

  always_comb begin
    case (tgt)
      TGT_DATA:    mux_byte = data_byte;
      TGT_FLAG:    mux_byte = {7'd0, irq_req};
      TGT_SCRATCH: mux_byte = scr_q[sub_addr[SAW-1:0]];
      default:     mux_byte = 8'h00;
    endcase
    rd_data_d = rd_ok ? mux_byte : rd_data_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_ok;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_valid_q && !rd_ok) |=> !rd_valid_q); // R4
  AST_FOREIGN_RD_SILENT: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_en && !wr_en && bus_addr != board_id) |=> !rd_valid_q); // R11
  AST_FLAG_RD_NOCLR: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_ok && tgt == TGT_FLAG && irq_req) |=> irq_req); // R6
endmodule

// File: tb/regbus_irq_readout_test.sv
module regbus_irq_readout_test;
  localparam int DEPTH = 10252;
  localparam int AW = $clog2(DEPTH);
  localparam int NV = 26;

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] board_id, bus_addr;
  logic [7:0] sub_addr, wr_data, rd_data;
  logic wr_en, rd_en, rd_valid, ram_done, irq_req;
  logic [AW-1:0] ram_addr;
  logic [15:0] ram_word;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // memory model: high byte = addr^0x5A, low byte = addr+0x11
  assign ram_word = {ram_addr[7:0] ^ 8'h5A, ram_addr[7:0] + 8'h11};

  regbus_irq_readout #(.RAM_DEPTH(DEPTH), .NREG(8)) uut (
    .clk(clk), .rst_n(rst_n), .board_id(board_id), .bus_addr(bus_addr),
    .sub_addr(sub_addr), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .ram_done(ram_done),
    .ram_addr(ram_addr), .ram_word(ram_word), .irq_req(irq_req)
  );

  // {op, bus, sub, data, exp_valid, exp_data, exp_irq}; op 0 idle,1 wr,2 rd,3 done
  localparam logic [32:0] VEC [NV] = '{
    {2'd1, 5'd5,  8'h03, 8'hA7, 1'b0, 8'h00, 1'b0}, // R3 write byte reg
    {2'd2, 5'd5,  8'h03, 8'h00, 1'b1, 8'hA7, 1'b0}, // R3 read back
    {2'd2, 5'd5,  8'h0C, 8'h00, 1'b1, 8'h5A, 1'b0}, // R1 word0 high
    {2'd2, 5'd5,  8'h0C, 8'h00, 1'b1, 8'h11, 1'b0}, // R1 word0 low
    {2'd2, 5'd5,  8'h0C, 8'h00, 1'b1, 8'h5B, 1'b0}, // R2 word1 high
    {2'd2, 5'd5,  8'h05, 8'h00, 1'b1, 8'h00, 1'b0}, // R3 other read mid-word
    {2'd2, 5'd5,  8'h0C, 8'h00, 1'b1, 8'h12, 1'b0}, // R1 word1 low after foreign read
    {2'd3, 5'd0,  8'h00, 8'h00, 1'b0, 8'h00, 1'b1}, // R5 set
    {2'd2, 5'd5,  8'h08, 8'h00, 1'b1, 8'h01, 1'b1}, // R6 poll
    {2'd2, 5'd5,  8'h08, 8'h00, 1'b1, 8'h01, 1'b1}, // R6 poll again, not cleared
    {2'd1, 5'd5,  8'h08, 8'h00, 1'b0, 8'h00, 1'b0}, // R7 clear with zero data
    {2'd3, 5'd0,  8'h00, 8'h00, 1'b0, 8'h00, 1'b1}, // R5 set again
    {2'd1, 5'd30, 8'h08, 8'hFF, 1'b0, 8'h00, 1'b0}, // R10 broadcast clear
    {2'd1, 5'd30, 8'h02, 8'h3C, 1'b0, 8'h00, 1'b0}, // R10 broadcast write
    {2'd2, 5'd5,  8'h02, 8'h00, 1'b1, 8'h3C, 1'b0}, // R10 accepted
    {2'd1, 5'd7,  8'h02, 8'h99, 1'b0, 8'h00, 1'b0}, // R10 foreign write
    {2'd2, 5'd5,  8'h02, 8'h00, 1'b1, 8'h3C, 1'b0}, // R10 ignored
    {2'd2, 5'd30, 8'h0C, 8'h00, 1'b0, 8'h00, 1'b0}, // R11 broadcast read
    {2'd2, 5'd7,  8'h0C, 8'h00, 1'b0, 8'h00, 1'b0}, // R11 foreign read
    {2'd2, 5'd5,  8'h0C, 8'h00, 1'b1, 8'h58, 1'b0}, // R11 pointer still word2
    {2'd3, 5'd0,  8'h00, 8'h00, 1'b0, 8'h00, 1'b1}, // R5 set
    {2'd1, 5'd5,  8'h09, 8'h00, 1'b0, 8'h00, 1'b0}, // R8 start clears
    {2'd2, 5'd5,  8'h0C, 8'h00, 1'b1, 8'h5A, 1'b0}, // R8 rewound to word0 high
    {2'd2, 5'd5,  8'h1F, 8'h00, 1'b1, 8'h00, 1'b0}, // R3 unmapped
    {2'd1, 5'd5,  8'h0C, 8'h77, 1'b0, 8'h00, 1'b0}, // R3 write to data ignored
    {2'd2, 5'd5,  8'h0C, 8'h00, 1'b1, 8'h11, 1'b0}  // R3 phase kept, word0 low
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [4:0] ba,
                       input logic [7:0] sa, input logic [7:0] wd, input bit done);
    @(negedge clk);
    bus_addr = ba; sub_addr = sa; wr_data = wd;
    wr_en = (op == 2'd1); rd_en = (op == 2'd2); ram_done = done || (op == 2'd3);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; ram_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    board_id = 5'd5; bus_addr = '0; sub_addr = '0; wr_data = '0;
    wr_en = 0; rd_en = 0; ram_done = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(irq_req == 0 && rd_valid == 0 && rd_data == 0 && ram_addr == 0, "R12",
        {irq_req, rd_valid, rd_data, 16'(ram_addr)}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R-vec%0d", i);
      do_op(v[32:31], v[30:26], v[25:18], v[17:10], 1'b0);
      if (v[9]) chk(rd_valid && rd_data == v[8:1], tag, {rd_valid, rd_data}, {1'b1, v[8:1]});
      else      chk(!rd_valid, tag, rd_valid, 0);
      chk(irq_req == v[0], tag, irq_req, v[0]);
    end

    // R4 valid lasts one cycle
    do_op(2'd2, 5'd5, 8'h03, 8'h00, 1'b0);
    chk(rd_valid == 1, "R4", rd_valid, 1);
    @(negedge clk);
    chk(rd_valid == 0, "R4", rd_valid, 0);

    // R9 clear beats set: interrupt-register write and done together
    do_op(2'd1, 5'd5, 8'h08, 8'h55, 1'b1);
    chk(irq_req == 0, "R9", irq_req, 0);
    do_op(2'd3, 5'd0, 8'h00, 8'h00, 1'b0);
    chk(irq_req == 1, "R5", irq_req, 1);
    // R9 with start command and done together
    do_op(2'd1, 5'd30, 8'h09, 8'h00, 1'b1);
    chk(irq_req == 0 && ram_addr == 0, "R9", {irq_req, 16'(ram_addr)}, 0);

    // R2 full pass and wrap
    begin
      int bad = 0;
      for (int k = 0; k < DEPTH; k++) begin
        logic [7:0] kb;
        kb = 8'(k);
        do_op(2'd2, 5'd5, 8'h0C, 8'h00, 1'b0);
        if (rd_data != (kb ^ 8'h5A)) bad++;
        do_op(2'd2, 5'd5, 8'h0C, 8'h00, 1'b0);
        if (rd_data != (kb + 8'h11)) bad++;
      end
      chk(bad == 0, "R2", bad, 0);
      chk(ram_addr == 0, "R2", 32'(ram_addr), 0);
      do_op(2'd2, 5'd5, 8'h0C, 8'h00, 1'b0);
      chk(rd_data == 8'h5A, "R2", rd_data, 8'h5A);
    end

    finish_run();
  end
endmodule